// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address Filter

This block receives characters from an asynchronous serial line. It has no baud divider of its own. An external divider gives it a one-cycle oversample tick, `OVS` times per bit period. The line goes through a synchronizer. The receiver then looks for a falling edge on a tick and confirms the start bit half a bit period later. After that it samples 8 or 9 data bits, least significant bit first, in the middle of each bit period, and then samples the stop bit.

Each completed character is written, together with its own framing flag, into a holding buffer that holds two characters. A third character can be shifting in while the buffer is full. The interrupt output is high while the buffer holds at least one character. The oldest character is always shown at the read outputs, and a read strobe removes it.

A character that arrives while the buffer is full is dropped and sets a sticky overrun flag. While the flag is set, nothing more is stored. Taking the receive enable low clears the flag and the buffer. In 9-bit mode an address filter can be switched on. When it is on, characters whose ninth bit is 0 are thrown away.

The receiver is a four-state machine:

| State | Activity |
|---|---|
| IDLE | Waits for a tick with the line low. |
| START | Counts half a bit period. |
| DATA | Shifts in one bit every `OVS` ticks. |
| STOP | Samples the stop bit after one more bit period. |

| Transition | Condition |
|---|---|
| IDLE to START | A tick sees the line low. |
| START to IDLE | The mid-bit sample is high (the start is rejected). |
| START to DATA | The mid-bit sample is low. |
| DATA to STOP | The last data bit has been sampled. |
| STOP to IDLE | The stop bit has been sampled. The character is offered to the buffer on that tick. |
| Any state to IDLE | Receive enable is low. |

Top module: `arx_receiver`

## Requirements
- R1: After reset, `rd_data` is 0, `rd_ferr` is 0, `rx_irq` is 0 and `ovr_err` is 0.
- R2: A low line seen on a tick in IDLE is checked again `OVS/2` ticks later. If the line is high at that check, the receiver goes back to IDLE and no character is produced.
- R3: With `nine_bit_en` = 0, eight data bits are sampled least significant bit first, each in the middle of its bit period. The character shows on `rd_data[7:0]` and `rd_data[8]` is 0.
- R4: With `nine_bit_en` = 1, nine data bits are sampled. The last bit received shows on `rd_data[8]`.
- R5: The stop bit is sampled one bit period after the last data bit. If it is low, `rd_ferr` is 1 for that character. If it is high, `rd_ferr` is 0. The character is stored in both cases.
- R6: The buffer holds up to two characters, oldest first. `rx_irq` is 1 while it is not empty. A `rd_strobe` pulse removes the oldest character on the next clock edge. A pulse while the buffer is empty has no effect. An empty buffer shows 0 on `rd_data` and `rd_ferr`.
- R7: A character that completes while two characters are unread is dropped and sets `ovr_err`. The two stored characters are not changed. A character that completes on the same edge as a read of a full buffer is stored, and no overrun is flagged.
- R8: While `ovr_err` is 1, no character is stored, even after the buffer has been read empty.
- R9: While `rx_enable` is 0, the buffer is empty, `ovr_err` is 0 and the receiver stays in IDLE. A character sent after enable returns high is received normally.
- R10: With `nine_bit_en` = 1 and `addr_only_en` = 1, a character whose ninth bit is 0 is thrown away without setting `ovr_err`, and one whose ninth bit is 1 is stored. With `nine_bit_en` = 0, `addr_only_en` has no effect.
- R11: A character shows at the outputs on the clock edge that carries its stop-bit sampling tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Serial input line, idle high |
| os_tick | input | 1 | Oversample tick, `OVS` pulses per bit period |
| nine_bit_en | input | 1 | 1: nine data bits, 0: eight data bits |
| addr_only_en | input | 1 | In 9-bit mode, keep only characters whose ninth bit is 1 |
| rx_enable | input | 1 | Receive enable; when low, clears the buffer and the overrun flag |
| rd_strobe | input | 1 | Removes the oldest buffered character |
| rd_data | output | 9 | Oldest buffered character, 0 when empty |
| rd_ferr | output | 1 | Framing flag of the oldest character |
| rx_irq | output | 1 | Buffer not empty |
| ovr_err | output | 1 | Sticky overrun flag |

## Verification
The bench goes after these corner cases:

- **Start-bit glitch.** A low pulse shorter than half a bit tests the start check. A receiver that skipped the check would produce a spurious character.
- **Third character.** Sending a third character without reading tests overrun. A buffer that overwrote the oldest entry, or did not set the flag, would show the wrong head or a clear `ovr_err`.
- **Read on the completing edge.** A third character that completes on the same edge as a read separates full-and-read from full. A design that tested fullness before the read would flag a false overrun.
- **Lockout and mode settings.** The bench checks that overrun blocks storage until enable is toggled. It checks that the address filter drops only characters with the ninth bit at 0, and only in 9-bit mode. It checks that the framing flag stays with its own character rather than with the buffer.

// File: rtl/arx_pkg.sv
package arx_pkg;

    localparam int CHAR_W = 9;

    typedef logic [CHAR_W-1:0] char_t;

    typedef struct packed {
        logic  ferr;
        char_t data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RESET_VAL}};
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/arx_shifter.sv
module arx_shifter
    import arx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable_i,
    input  logic      tick_i,
    input  logic      line_i,
    input  logic      nine_i,
    input  logic      addr_only_i,
    output logic      push_o,
    output rx_entry_t entry_o
);

    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;
    localparam int BW   = $clog2(CHAR_W + 1);

    rx_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic [BW-1:0]   bit_q;
    char_t           shreg_q;
    char_t           data_w;
    logic            half_hit, full_hit, last_bit, keep_w;

    assign half_hit = (cnt_q == CW'(HALF - 1));
    assign full_hit = (cnt_q == CW'(OVS - 1));
    assign last_bit = (bit_q == (nine_i ? BW'(CHAR_W - 1) : BW'(CHAR_W - 2)));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (tick_i && !line_i)              state_d = RX_START;
            RX_START: if (tick_i && half_hit)             state_d = line_i ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick_i && full_hit && last_bit) state_d = RX_STOP;
            RX_STOP:  if (tick_i && full_hit)             state_d = RX_IDLE;
            default:                                      state_d = RX_IDLE;
        endcase
        if (!enable_i) state_d = RX_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // tick counter, bit counter and shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
        end else if (!enable_i) begin
            cnt_q <= '0;
            bit_q <= '0;
        end else begin
            unique case (state_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    bit_q <= '0;
                end
                RX_START: begin
                    if (tick_i) cnt_q <= half_hit ? '0 : cnt_q + 1'b1;
                end
                RX_DATA: begin
                    if (tick_i) begin
                        if (full_hit) begin
                            cnt_q   <= '0;
                            bit_q   <= bit_q + 1'b1;
                            shreg_q <= {line_i, shreg_q[CHAR_W-1:1]};
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick_i) cnt_q <= full_hit ? '0 : cnt_q + 1'b1;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        data_w       = nine_i ? shreg_q : {1'b0, shreg_q[CHAR_W-1:1]};
        keep_w       = !(nine_i && addr_only_i && !data_w[CHAR_W-1]);
        push_o       = enable_i && (state_q == RX_STOP) && tick_i && full_hit && keep_w;
        entry_o.data = data_w;
        entry_o.ferr = !line_i;
    end

    // R2
    // Entering DATA from START requires the mid-bit sample to have been low.
    start_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_DATA && $past(state_q) == RX_START) |-> !$past(line_i));

endmodule

// File: rtl/arx_rxbuf.sv
module arx_rxbuf
    import arx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable_i,
    input  logic      push_i,
    input  rx_entry_t entry_i,
    input  logic      pop_i,
    output rx_entry_t head_o,
    output logic      nonempty_o,
    output logic      ovr_o
);

    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    rx_entry_t       mem_q [DEPTH];
    logic [PW-1:0]   wr_q, rd_q;
    logic [CNTW-1:0] count_q;
    logic            ovr_q;
    logic            pop, full_eff, store, overflow;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop      = pop_i && (count_q != '0);
    assign full_eff = (count_q == CNTW'(DEPTH)) && !pop;
    assign store    = push_i && !ovr_q && !full_eff;
    assign overflow = push_i && !ovr_q && full_eff;

    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
            ovr_q   <= 1'b0;
        end else begin
            if (store) wr_q <= ptr_next(wr_q);
            if (pop)   rd_q <= ptr_next(rd_q);
            count_q <= count_q + CNTW'(store) - CNTW'(pop);
            if (overflow) ovr_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (store && wr_q == PW'(i)) mem_q[i] <= entry_i;
        end
    end

    assign nonempty_o = (count_q != '0);
    assign head_o     = nonempty_o ? mem_q[rd_q] : '0;
    assign ovr_o      = ovr_q;

    // R7
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && enable_i) |=> ovr_q);

    // R8
    ovr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |=> (count_q <= $past(count_q)));

    // R9
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (count_q == '0 && !ovr_q));

    // R6
    pop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && pop_i && count_q != '0 && !push_i) |=> (count_q == $past(count_q) - CNTW'(1)));

endmodule

// File: rtl/arx_receiver.sv
module arx_receiver
    import arx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DEPTH       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              os_tick,
    input  logic              nine_bit_en,
    input  logic              addr_only_en,
    input  logic              rx_enable,
    input  logic              rd_strobe,
    output logic [CHAR_W-1:0] rd_data,
    output logic              rd_ferr,
    output logic              rx_irq,
    output logic              ovr_err
);

    logic      line_s;
    logic      sh_push;
    rx_entry_t sh_entry;
    rx_entry_t head;

    arx_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (rx_line),
        .q_o  (line_s)
    );

    arx_shifter #(
        .OVS(OVS)
    ) shifter_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (rx_enable),
        .tick_i     (os_tick),
        .line_i     (line_s),
        .nine_i     (nine_bit_en),
        .addr_only_i(addr_only_en),
        .push_o     (sh_push),
        .entry_o    (sh_entry)
    );

    arx_rxbuf #(
        .DEPTH(DEPTH)
    ) buf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (rx_enable),
        .push_i    (sh_push),
        .entry_i   (sh_entry),
        .pop_i     (rd_strobe),
        .head_o    (head),
        .nonempty_o(rx_irq),
        .ovr_o     (ovr_err)
    );

    assign rd_data = head.data;
    assign rd_ferr = head.ferr;

    // R10
    addr_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_push && nine_bit_en && addr_only_en) |-> sh_entry.data[CHAR_W-1]);

endmodule

// File: tb/arx_receiver_tb_top.sv
`timescale 1ns/1ps
module arx_receiver_tb_top;

    localparam int OVS  = 16;
    localparam int HALF = OVS / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic       nine_bit_en = 1'b0;
    logic       addr_only_en = 1'b0;
    logic       rx_enable = 1'b1;
    logic       rd_strobe = 1'b0;
    logic [8:0] rd_data;
    logic       rd_ferr, rx_irq, ovr_err;

    logic       cf = 1'b0;
    logic [8:0] cur_val = '0;
    logic       cur_ferr = 1'b0;
    logic [9:0] mq[$];
    logic       m_ovr = 1'b0;
    bit         run_cmp = 1'b0;
    string      cur_req = "R1";
    int         compared = 0;
    int         mismatched = 0;

    always #2.5 clk = ~clk;

    arx_receiver #(.OVS(OVS)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
        .nine_bit_en(nine_bit_en), .addr_only_en(addr_only_en),
        .rx_enable(rx_enable), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .rd_ferr(rd_ferr), .rx_irq(rx_irq), .ovr_err(ovr_err)
    );

    // reference model (R6 R7 R8 R9 R10 R11)
    always @(posedge clk) begin
        if (!rst_n || !rx_enable) begin
            mq.delete();
            m_ovr = 1'b0;
        end else begin
            if (rd_strobe && mq.size() > 0) void'(mq.pop_front());
            if (os_tick && cf && !(nine_bit_en && addr_only_en && !cur_val[8])) begin
                if (!m_ovr) begin
                    if (mq.size() < 2) mq.push_back({cur_ferr, cur_val});
                    else m_ovr = 1'b1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            logic [8:0] ed;
            logic       ef;
            ed = (mq.size() > 0) ? mq[0][8:0] : 9'h0;
            ef = (mq.size() > 0) ? mq[0][9] : 1'b0;
            compared++;
            if ({rx_irq, ovr_err, rd_data, rd_ferr} !== {mq.size() > 0, m_ovr, ed, ef}) begin
                mismatched++;
                $display("FAIL %s: irq/ovr/data/ferr got %b/%b/%h/%b expected %b/%b/%h/%b",
                         cur_req, rx_irq, ovr_err, rd_data, rd_ferr,
                         mq.size() > 0, m_ovr, ed, ef);
            end
        end
    end

    task automatic expect_out(input string req, input logic [8:0] d, input logic f,
                              input logic irq, input logic ov);
        @(negedge clk);
        compared++;
        if ({rd_data, rd_ferr, rx_irq, ovr_err} !== {d, f, irq, ov}) begin
            mismatched++;
            $display("FAIL %s: data/ferr/irq/ovr got %h/%b/%b/%b expected %h/%b/%b/%b",
                     req, rd_data, rd_ferr, rx_irq, ovr_err, d, f, irq, ov);
        end
    endtask

    task automatic slot(input logic lvl, input logic commit, input logic rd);
        @(negedge clk);
        rx_line = lvl; os_tick = 1'b0; cf = 1'b0; rd_strobe = 1'b0;
        @(negedge clk);
        @(negedge clk);
        os_tick = 1'b1; cf = commit; rd_strobe = rd;
    endtask

    task automatic finish_slots();
        @(negedge clk);
        os_tick = 1'b0; cf = 1'b0; rd_strobe = 1'b0;
    endtask

    task automatic send_char(input logic [8:0] val, input logic stop_lvl, input logic rd_at_stop);
        int n, t_stop;
        n = nine_bit_en ? 9 : 8;
        t_stop = OVS * (n + 1) + HALF;
        cur_val  = nine_bit_en ? val : {1'b0, val[7:0]};
        cur_ferr = !stop_lvl;
        for (int t = 0; t <= t_stop; t++) begin
            int k;
            logic lvl;
            k = t / OVS;
            lvl = (k == 0) ? 1'b0 : ((k <= n) ? val[k-1] : stop_lvl);
            slot(lvl, t == t_stop, rd_at_stop && (t == t_stop));
        end
        for (int i = 0; i < 3; i++) slot(1'b1, 1'b0, 1'b0);
        finish_slots();
    endtask

    task automatic do_read();
        @(negedge clk);
        os_tick = 1'b0; cf = 1'b0; rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog (R11 timing): run still active, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_out("R1", 9'h000, 1'b0, 1'b0, 1'b0);
        run_cmp = 1'b1;

        // R3 eight data bits, LSB first
        cur_req = "R3"; send_char(9'h0A5, 1'b1, 1'b0);
        expect_out("R3", 9'h0A5, 1'b0, 1'b1, 1'b0);
        do_read();
        expect_out("R6", 9'h000, 1'b0, 1'b0, 1'b0);

        // R4 nine data bits
        cur_req = "R4"; nine_bit_en = 1'b1;
        send_char(9'h1C3, 1'b1, 1'b0);
        expect_out("R4", 9'h1C3, 1'b0, 1'b1, 1'b0);
        do_read();
        nine_bit_en = 1'b0;

        // R5 framing error stays with its character
        cur_req = "R5"; send_char(9'h03C, 1'b0, 1'b0);
        send_char(9'h0C3, 1'b1, 1'b0);
        expect_out("R5", 9'h03C, 1'b1, 1'b1, 1'b0);
        do_read();
        expect_out("R5", 9'h0C3, 1'b0, 1'b1, 1'b0);
        do_read();

        // R2 short low pulse is rejected
        cur_req = "R2";
        for (int i = 0; i < 3; i++) slot(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < HALF + 6; i++) slot(1'b1, 1'b0, 1'b0);
        finish_slots();
        expect_out("R2", 9'h000, 1'b0, 1'b0, 1'b0);

        // R6 two-entry ordering, read when empty
        cur_req = "R6";
        send_char(9'h011, 1'b1, 1'b0);
        send_char(9'h022, 1'b1, 1'b0);
        expect_out("R6", 9'h011, 1'b0, 1'b1, 1'b0);
        do_read();
        expect_out("R6", 9'h022, 1'b0, 1'b1, 1'b0);
        do_read(); do_read();
        expect_out("R6", 9'h000, 1'b0, 1'b0, 1'b0);

        // R7 overrun on a third character
        cur_req = "R7";
        send_char(9'h031, 1'b1, 1'b0);
        send_char(9'h032, 1'b1, 1'b0);
        send_char(9'h033, 1'b1, 1'b0);
        expect_out("R7", 9'h031, 1'b0, 1'b1, 1'b1);
        do_read();
        expect_out("R7", 9'h032, 1'b0, 1'b1, 1'b1);
        do_read();

        // R8 lockout while overrun is set
        cur_req = "R8"; send_char(9'h034, 1'b1, 1'b0);
        expect_out("R8", 9'h000, 1'b0, 1'b0, 1'b1);

        // R9 disable clears, re-enable receives
        cur_req = "R9";
        @(negedge clk); rx_enable = 1'b0;
        repeat (3) @(negedge clk);
        expect_out("R9", 9'h000, 1'b0, 1'b0, 1'b0);
        rx_enable = 1'b1;
        send_char(9'h055, 1'b1, 1'b0);
        expect_out("R9", 9'h055, 1'b0, 1'b1, 1'b0);
        do_read();

        // R7 read on the completing edge of a full buffer
        cur_req = "R7";
        send_char(9'h061, 1'b1, 1'b0);
        send_char(9'h062, 1'b1, 1'b0);
        send_char(9'h063, 1'b1, 1'b1);
        expect_out("R7", 9'h062, 1'b0, 1'b1, 1'b0);
        do_read();
        expect_out("R7", 9'h063, 1'b0, 1'b1, 1'b0);
        do_read();

        // R10 address filter
        cur_req = "R10"; nine_bit_en = 1'b1; addr_only_en = 1'b1;
        send_char(9'h0AB, 1'b1, 1'b0);
        expect_out("R10", 9'h000, 1'b0, 1'b0, 1'b0);
        send_char(9'h1AB, 1'b1, 1'b0);
        expect_out("R10", 9'h1AB, 1'b0, 1'b1, 1'b0);
        do_read();
        nine_bit_en = 1'b0;
        send_char(9'h077, 1'b1, 1'b0);
        expect_out("R10", 9'h077, 1'b0, 1'b1, 1'b0);
        do_read();
        addr_only_en = 1'b0;
        expect_out("R11", 9'h000, 1'b0, 1'b0, 1'b0);

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule